// File: doc/BRIEF.md
# Cascaded Interrupt Priority Resolver

This block resolves sixteen interrupt request lines through two eight-input priority controllers, a primary one and a secondary one whose combined request feeds primary input 2. It holds a request register and an in-service register for each controller. The `pending` output reports that some controller holds a request its mask does not block. When the processor side pulses `ack`, the block picks the winning request, forms an 8-bit vector from the owning controller's base byte plus the input index, and moves that request from the request register into the in-service register.

Masks, vector bases and end-of-interrupt clears are plain inputs that a separate command decoder drives. Each end-of-interrupt input is a per-bit clear mask applied to that controller's in-service register. Software that finishes a secondary interrupt clears both the secondary bit and primary bit 2.

Top module: `cirq_resolver`

## Requirements
- R1: After a synchronous reset, both request and in-service registers are zero, `pending` is 0 and `vec_valid` is 0.
- R2: A rising edge on line k (0 to 7) sets primary request bit k one clock later. While line k stays low the bit is clear, so `pending` falls once the only request line drops.
- R3: A rising edge on line k (8 to 15) sets secondary request bit k-8, which drives primary input 2. When input 2 wins and the secondary holds an eligible request, the vector is `slv_base` plus the secondary index, and primary in-service bit 2 is set along with the secondary bit.
- R4: A request whose mask bit is 1 does not raise `pending` and is never granted. Its request bit is kept, and it is served once it is unmasked.
- R5: Within each controller, lower input index has higher priority. Primary inputs 0 and 1 beat any secondary request.
- R6: `vec_valid` is high for exactly the one cycle after the cycle in which `ack` was sampled high, and `vec` then holds the vector for that acknowledge.
- R7: An acknowledge that grants input i clears request bit i and sets in-service bit i of the same controller.
- R8: A request at index i is not granted while any in-service bit at index i or lower is set in the same controller.
- R9: A bit set in `mst_eoi` or `slv_eoi` clears that in-service bit, which releases the blocked lower-priority requests.
- R10: An acknowledge with nothing eligible returns `mst_base` + 7 and changes no register.
- R11: A request is set only by a rising edge. A line held high after its grant does not request again until it drops and rises.
- R12: A request at a higher priority than every set in-service bit is granted while lower-priority service is still open, which allows nesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16 | Level request lines; 0 to 7 primary, 8 to 15 secondary |
| mst_mask | input | 8 | Primary mask, 1 blocks the input |
| slv_mask | input | 8 | Secondary mask, 1 blocks the input |
| mst_base | input | 8 | Primary vector base |
| slv_base | input | 8 | Secondary vector base |
| mst_eoi | input | 8 | Primary in-service clear mask, one-cycle strobe |
| slv_eoi | input | 8 | Secondary in-service clear mask, one-cycle strobe |
| ack | input | 1 | Acknowledge strobe |
| pending | output | 1 | An unmasked request exists in either controller |
| vec_valid | output | 1 | Vector valid, one cycle after acknowledge |
| vec | output | 8 | Registered interrupt vector |

## Verification
The bench checks primary line 0 against a secondary line, to confirm that primary input 0 outranks anything routed through input 2. A design that ranked the cascade wrongly would return a `slv_base` vector first. It leaves primary in-service bit 2 set after the secondary end-of-interrupt. A design that did not mark the cascade input would then grant the next secondary request too early instead of returning the spurious vector. It acknowledges a line that is still held high after its grant and after its end-of-interrupt. A level-retriggering design would hand out the same vector twice. It also checks masked requests that are unmasked later and a nested grant above an open service, where a design that lost the kept request bit, or one that blocked on every in-service bit, would give `mst_base` + 7 where a real vector is due.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
  localparam int unsigned DEF_LINES   = 8;
  localparam int unsigned DEF_VEC_W   = 8;
  localparam int unsigned DEF_CASCADE = 2;

  // Which controller supplies the vector of a grant
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_MST  = 2'd1,
    SRC_SLV  = 2'd2
  } grant_src_e;
endpackage

// File: rtl/cirq_prio_pick.sv
module cirq_prio_pick #(
  parameter int unsigned N = cirq_pkg::DEF_LINES,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  mask,
  input  logic [N-1:0]  isr,
  output logic          hit,
  output logic [IW-1:0] idx,
  output logic          any_open
);
  logic [N-1:0] elig;

  // An in-service bit at or below an index blocks that index
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < N; i++) begin
      acc     = acc | isr[i];
      elig[i] = req[i] & ~mask[i] & ~acc;
    end
  end

  // Lowest eligible index wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end

  assign any_open = |(req & ~mask);
endmodule

// File: rtl/cirq_ctrl_bank.sv
module cirq_ctrl_bank #(
  parameter int unsigned N = cirq_pkg::DEF_LINES,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  line,
  input  logic          isr_set,
  input  logic          irr_clr,
  input  logic [IW-1:0] sel_idx,
  input  logic [N-1:0]  eoi_clr,
  output logic [N-1:0]  irr_q,
  output logic [N-1:0]  isr_q
);
  logic [N-1:0] prev_q;
  logic [N-1:0] sel_1h;
  logic [N-1:0] rise;

  assign sel_1h = N'(1) << sel_idx;
  assign rise   = line & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      irr_q  <= '0;
      isr_q  <= '0;
    end else begin
      prev_q <= line;
      irr_q  <= (irr_q | rise) & line & ~(irr_clr ? sel_1h : '0);
      isr_q  <= (isr_q & ~eoi_clr) | (isr_set ? sel_1h : '0);
    end
  end
endmodule

// File: rtl/cirq_vec_form.sv
module cirq_vec_form #(
  parameter int unsigned N  = cirq_pkg::DEF_LINES,
  parameter int unsigned VW = cirq_pkg::DEF_VEC_W,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ack,
  input  cirq_pkg::grant_src_e   src,
  input  logic [IW-1:0]          m_idx,
  input  logic [IW-1:0]          s_idx,
  input  logic [VW-1:0]          mst_base,
  input  logic [VW-1:0]          slv_base,
  output logic                   vec_valid,
  output logic [VW-1:0]          vec
);
  import cirq_pkg::*;
  localparam logic [VW-1:0] SPUR_OFS = VW'(N - 1);

  logic [VW-1:0] vec_n;

  always_comb begin
    unique case (src)
      SRC_MST: vec_n = mst_base + VW'(m_idx);
      SRC_SLV: vec_n = slv_base + VW'(s_idx);
      default: vec_n = mst_base + SPUR_OFS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_valid <= 1'b0;
      vec       <= '0;
    end else begin
      vec_valid <= ack;
      if (ack) vec <= vec_n;
    end
  end
endmodule

// File: rtl/cirq_resolver.sv
module cirq_resolver #(
  parameter int unsigned N       = cirq_pkg::DEF_LINES,
  parameter int unsigned VW      = cirq_pkg::DEF_VEC_W,
  parameter int unsigned CASCADE = cirq_pkg::DEF_CASCADE
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2*N-1:0]  irq_in,
  input  logic [N-1:0]    mst_mask,
  input  logic [N-1:0]    slv_mask,
  input  logic [VW-1:0]   mst_base,
  input  logic [VW-1:0]   slv_base,
  input  logic [N-1:0]    mst_eoi,
  input  logic [N-1:0]    slv_eoi,
  input  logic            ack,
  output logic            pending,
  output logic            vec_valid,
  output logic [VW-1:0]   vec
);
  import cirq_pkg::*;
  localparam int unsigned IW = $clog2(N);

  logic [N-1:0]  m_irr_q, m_isr_q, s_irr_q, s_isr_q;
  logic [N-1:0]  m_req;
  logic          m_hit, s_hit, m_open, s_open;
  logic [IW-1:0] m_idx, s_idx;
  logic          slv_path;
  grant_src_e    src;

  // Secondary resolver: its own mask and in-service blocking
  cirq_prio_pick #(.N(N)) u_slv_pick (
    .req(s_irr_q), .mask(slv_mask), .isr(s_isr_q),
    .hit(s_hit), .idx(s_idx), .any_open(s_open)
  );

  // Cascade input carries the secondary's eligible request
  for (genvar g = 0; g < N; g++) begin : g_mreq
    if (g == CASCADE) begin : g_casc
      assign m_req[g] = m_irr_q[g] | s_hit;
    end else begin : g_plain
      assign m_req[g] = m_irr_q[g];
    end
  end

  cirq_prio_pick #(.N(N)) u_mst_pick (
    .req(m_req), .mask(mst_mask), .isr(m_isr_q),
    .hit(m_hit), .idx(m_idx), .any_open(m_open)
  );

  assign slv_path = m_hit && (m_idx == IW'(CASCADE)) && s_hit;

  always_comb begin
    if (!m_hit)        src = SRC_NONE;
    else if (slv_path) src = SRC_SLV;
    else               src = SRC_MST;
  end

  cirq_ctrl_bank #(.N(N)) u_mst_bank (
    .clk(clk), .rst(rst), .line(irq_in[N-1:0]),
    .isr_set(ack && m_hit), .irr_clr(ack && m_hit && !slv_path),
    .sel_idx(m_idx), .eoi_clr(mst_eoi),
    .irr_q(m_irr_q), .isr_q(m_isr_q)
  );

  cirq_ctrl_bank #(.N(N)) u_slv_bank (
    .clk(clk), .rst(rst), .line(irq_in[2*N-1:N]),
    .isr_set(ack && slv_path), .irr_clr(ack && slv_path),
    .sel_idx(s_idx), .eoi_clr(slv_eoi),
    .irr_q(s_irr_q), .isr_q(s_isr_q)
  );

  cirq_vec_form #(.N(N), .VW(VW)) u_vec (
    .clk(clk), .rst(rst), .ack(ack), .src(src),
    .m_idx(m_idx), .s_idx(s_idx),
    .mst_base(mst_base), .slv_base(slv_base),
    .vec_valid(vec_valid), .vec(vec)
  );

  assign pending = m_open | s_open;
endmodule

// File: rtl/cirq_resolver_chk.sv
module cirq_resolver_chk #(
  parameter int unsigned N       = 8,
  parameter int unsigned VW      = 8,
  parameter int unsigned CASCADE = 2
) (
  input logic           clk,
  input logic           rst,
  input logic [2*N-1:0] irq_in,
  input logic [N-1:0]   mst_mask,
  input logic [N-1:0]   slv_mask,
  input logic [VW-1:0]  mst_base,
  input logic [N-1:0]   mst_eoi,
  input logic [N-1:0]   slv_eoi,
  input logic           ack,
  input logic           pending,
  input logic           vec_valid,
  input logic [VW-1:0]  vec,
  input logic [N-1:0]   m_irr,
  input logic [N-1:0]   m_isr,
  input logic [N-1:0]   s_isr
);
  AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    ack |=> vec_valid); // R6
  AST_VEC_ONLY_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    !ack |=> !vec_valid); // R6
  AST_IRR_NEEDS_LINE: assert property (@(posedge clk) disable iff (rst)
    (m_irr != '0) |-> ((m_irr & ~$past(irq_in[N-1:0])) == '0)); // R2
  AST_MASK_ALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((mst_mask == '1) && (slv_mask == '1)) |-> !pending); // R4
  AST_SPURIOUS_VEC: assert property (@(posedge clk) disable iff (rst)
    (ack && !pending) |=> (vec == $past(mst_base) + VW'(N - 1))); // R10
  AST_ISR_GROWS_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    (ack && (mst_eoi == '0) && (slv_eoi == '0)) |=>
      ($countones({m_isr, s_isr}) >= $past($countones({m_isr, s_isr})))); // R7
  AST_SLV_MARKS_CASCADE: assert property (@(posedge clk) disable iff (rst)
    ($countones(s_isr) > $past($countones(s_isr))) |-> m_isr[CASCADE]); // R3
endmodule

bind cirq_resolver cirq_resolver_chk #(.N(N), .VW(VW), .CASCADE(CASCADE)) u_chk (
  .clk(clk), .rst(rst), .irq_in(irq_in), .mst_mask(mst_mask),
  .slv_mask(slv_mask), .mst_base(mst_base), .mst_eoi(mst_eoi),
  .slv_eoi(slv_eoi), .ack(ack), .pending(pending),
  .vec_valid(vec_valid), .vec(vec),
  .m_irr(m_irr_q), .m_isr(m_isr_q), .s_isr(s_isr_q)
);

// File: tb/test_cirq_resolver.sv
module test_cirq_resolver;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_in = '0;
  logic [7:0]  mst_mask = '0, slv_mask = '0;
  logic [7:0]  mst_base = 8'h40, slv_base = 8'h70;
  logic [7:0]  mst_eoi = '0, slv_eoi = '0;
  logic        ack = 1'b0;
  logic        pending, vec_valid;
  logic [7:0]  vec;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  cirq_resolver i_cirq_resolver (
    .clk(clk), .rst(rst), .irq_in(irq_in), .mst_mask(mst_mask),
    .slv_mask(slv_mask), .mst_base(mst_base), .slv_base(slv_base),
    .mst_eoi(mst_eoi), .slv_eoi(slv_eoi), .ack(ack),
    .pending(pending), .vec_valid(vec_valid), .vec(vec)
  );

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected finish before 5000", cyc);
      summary();
      $finish;
    end
  end

  // Monitor: every vector that appears is matched against the scoreboard
  always @(negedge clk) begin
    if (!rst && vec_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6 unexpected vector: actual %02h expected none", vec);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (vec !== e) begin
          errors++;
          $display("FAIL %s vector: actual %02h expected %02h", t, vec, e);
        end
      end
    end
  end

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic check_pend(logic exp, string tag);
    checks++;
    if (pending !== exp) begin
      errors++;
      $display("FAIL %s pending: actual %0b expected %0b", tag, pending, exp);
    end
  endtask

  // Driver: push the expected vector, then pulse ack for one cycle
  task automatic ack_expect(logic [7:0] e, string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    ack = 1'b1;
    tick();
    ack = 1'b0;
    tick();
  endtask

  task automatic eoi(logic [7:0] m, logic [7:0] s);
    mst_eoi = m;
    slv_eoi = s;
    tick();
    mst_eoi = '0;
    slv_eoi = '0;
    tick();
  endtask

  task automatic lines(logic [15:0] v);
    irq_in = v;
    tick();
  endtask

  initial begin
    tick(3);
    checks++;
    if (pending !== 1'b0 || vec_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual pend %0b valid %0b expected 0 0", pending, vec_valid);
    end
    rst = 1'b0;
    tick();
    check_pend(1'b0, "R1");

    // R2 request follows rising edge, drops with line
    lines(16'h0040);
    check_pend(1'b1, "R2");
    lines(16'h0000);
    check_pend(1'b0, "R2");

    // R6 R7 grant, R11 held line does not re-request
    lines(16'h0020);
    check_pend(1'b1, "R2");
    ack_expect(8'h45, "R6");
    check_pend(1'b0, "R7");
    eoi(8'h20, 8'h00);
    ack_expect(8'h47, "R11");
    lines(16'h0000);

    // R4 masked request kept, served after unmask
    mst_mask = 8'h08;
    lines(16'h0008);
    check_pend(1'b0, "R4");
    ack_expect(8'h47, "R4");
    mst_mask = 8'h00;
    tick();
    check_pend(1'b1, "R4");
    ack_expect(8'h43, "R4");
    eoi(8'h08, 8'h00);
    lines(16'h0000);

    // R5 priority, R8 blocking, R9 release
    lines(16'h0012);
    ack_expect(8'h41, "R5");
    ack_expect(8'h47, "R8");
    eoi(8'h02, 8'h00);
    ack_expect(8'h44, "R9");
    eoi(8'h10, 8'h00);
    lines(16'h0000);

    // R3 secondary request through cascade
    lines(16'h0800);
    check_pend(1'b1, "R3");
    ack_expect(8'h73, "R3");
    eoi(8'h04, 8'h08);
    lines(16'h0000);

    // R5 primary 0 beats secondary
    lines(16'h0201);
    ack_expect(8'h40, "R5");
    ack_expect(8'h47, "R8");
    eoi(8'h01, 8'h00);
    ack_expect(8'h71, "R5");
    eoi(8'h04, 8'h02);
    lines(16'h0000);

    // R12 nesting above open service
    lines(16'h0040);
    ack_expect(8'h46, "R12");
    lines(16'h0048);
    ack_expect(8'h43, "R12");
    eoi(8'h48, 8'h00);
    lines(16'h0000);

    // R3 R8 cascade bit blocks until primary end-of-interrupt
    lines(16'h4400);
    ack_expect(8'h72, "R3");
    ack_expect(8'h47, "R8");
    eoi(8'h00, 8'h04);
    ack_expect(8'h47, "R3");
    eoi(8'h04, 8'h00);
    ack_expect(8'h76, "R9");
    eoi(8'h04, 8'h40);
    lines(16'h0000);

    // R4 secondary mask, R10 spurious changes nothing
    slv_mask = 8'h01;
    lines(16'h0100);
    check_pend(1'b0, "R4");
    ack_expect(8'h47, "R10");
    slv_mask = 8'h00;
    tick();
    ack_expect(8'h70, "R10");
    eoi(8'h04, 8'h01);
    lines(16'h0000);
    ack_expect(8'h47, "R10");

    tick(3);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R6 missing vectors: actual %0d left expected 0", exp_q.size());
    end
    summary();
    $finish;
  end
endmodule